// File: doc/BRIEF.md
# Byte-lane SRAM slave for a single-master AHB-Lite bus

This block is a memory target on a single-master AHB-Lite bus. The memory is 16 KB, split into four banks. Each bank is 8 bits wide and 4096 words deep, and each bank serves one byte lane of the 32-bit data bus. An external decoder drives `hsel` for a 1 MB window. Inside that window only the low address bits index the memory, so the 16 KB image repeats across the whole window.

The bus is pipelined. In the address phase the block samples the address and control, and in the following data phase it performs the access. A read that does not follow a write starts the bank read at the end of its address phase, so the data is registered and ready in the data phase with no wait state. A write takes its data from `hwdata` in the data phase and applies it with the lane enables registered in the address phase. Lane enables are derived from `hsize` and the two low address bits, so byte, halfword and word writes are all supported.

Each bank has a single port. A read accepted in the cycle right after a write would collide with that write in the banks. The block resolves this with exactly one dead cycle: `hreadyout` goes low for one cycle, and the read then returns data that already includes the preceding write. The only response the block gives is OKAY. Bursts, split and retry are not handled.

Top module: `ahb_byte_sram`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `hreadyout` is 1 and `hresp` is 2'b00 (OKAY).
- R2: A transfer is accepted only when `hsel`=1, `htrans[1]`=1 and `hready`=1. `htrans` 2'b10 (NONSEQ) and 2'b11 (SEQ) are both accepted. A cycle with `htrans` 2'b00 (IDLE), `htrans` 2'b01 (BUSY) or `hsel`=0 touches no bank, so a write presented that way leaves the memory unchanged.
- R3: A read returns the whole addressed word on `hrdata` in its data phase, for every `hsize`. Lane k (`hrdata[8k+7:8k]`) holds byte k of the word.
- R4: A write with `hsize`=3'b010 (word) stores all four lanes of `hwdata`, sampled in the data phase.
- R5: A write with `hsize`=3'b001 (halfword) stores lanes 0 and 1 when `haddr[1]`=0, or lanes 2 and 3 when `haddr[1]`=1. The other lanes keep their contents.
- R6: A write with `hsize`=3'b000 (byte) stores only lane `haddr[1:0]`. The other three lanes keep their contents.
- R7: The word index is `haddr[13:2]`. Address bits 31:14 are ignored, so addresses that differ only above bit 13 reach the same word.
- R8: When a read is accepted in the cycle directly after an accepted write, its data phase has `hreadyout`=0 for exactly one cycle. It then completes with data that includes that write, including when both transfers address the same word.
- R9: Every other data phase completes with no wait state: writes, reads after reads, and reads separated from a write by at least one cycle with no transfer.
- R10: `hresp` is OKAY (2'b00) in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hsel | input | 1 | Slave select from the address decoder |
| haddr | input | 32 | Byte address, sampled in the address phase |
| htrans | input | 2 | Transfer type; bit 1 marks an active transfer |
| hwrite | input | 1 | 1 = write, 0 = read |
| hsize | input | 3 | 000 byte, 001 halfword, 010 word |
| hwdata | input | 32 | Write data, valid in the data phase |
| hready | input | 1 | Bus-wide ready; the previous transfer has finished |
| hrdata | output | 32 | Read data, registered |
| hreadyout | output | 1 | Ready of this slave, registered |
| hresp | output | 2 | Transfer response, always OKAY |

## Verification
A registered lane mask or word index that has gone wrong does not show at write time. It shows on the first later read of that word, because `hrdata` then differs in exactly the lanes that were or were not written. A pending-write flag that is set wrongly shows one cycle after the next read is accepted, as a missing or extra low cycle on `hreadyout`. If instead the flag hides a collision, the read returns the previous contents of the bank rather than the new data. A write enable asserted outside a write data phase corrupts a word silently, and only a read-back of that word exposes it. For that reason the bench reads back every word after an IDLE, BUSY or deselected write.

// File: rtl/ahb_sram_pkg.sv
package ahb_sram_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  typedef enum logic [1:0] {
    RSP_OKAY  = 2'b00,
    RSP_ERROR = 2'b01,
    RSP_RETRY = 2'b10,
    RSP_SPLIT = 2'b11
  } resp_e;

  localparam logic [2:0] SZ_BYTE = 3'b000;
  localparam logic [2:0] SZ_HALF = 3'b001;
  localparam logic [2:0] SZ_WORD = 3'b010;

endpackage

// File: rtl/ahb_sram_bank.sv
// One byte lane: single port, synchronous read, no reset on the array so
// that a block RAM can be inferred.
module ahb_sram_bank #(
  parameter int DEPTH = 4096,
  parameter int WIDTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             ce,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (ce) begin
      if (we) begin
        mem[idx] <= din;
      end else begin
        dout <= mem[idx];
      end
    end
  end

endmodule

// File: rtl/ahb_sram_ctrl.sv
// Phase tracking, lane decode and bank port arbitration.
module ahb_sram_ctrl #(
  parameter int LANES = 4,
  parameter int DEPTH = 4096,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int OFF_W = $clog2(LANES),
  localparam int LOW_W = IDX_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hsel,
  input  logic [LOW_W-1:0] addr_lo,
  input  logic             trans_active,
  input  logic             hwrite,
  input  logic [2:0]       hsize,
  input  logic             hready,
  output logic             hreadyout,
  output logic [LANES-1:0] bank_ce,
  output logic [LANES-1:0] bank_we,
  output logic [IDX_W-1:0] bank_idx
);

  // Lanes touched by a transfer of size sz starting at byte offset off.
  function automatic logic [LANES-1:0] lanes_for(input logic [2:0] sz,
                                                 input logic [OFF_W-1:0] off);
    logic [LANES-1:0] m;
    m = '0;
    for (int k = 0; k < LANES; k++) begin
      if (int'(sz) >= OFF_W) begin
        m[k] = 1'b1;
      end else begin
        m[k] = ((k >> sz) == (int'(off) >> sz));
      end
    end
    return m;
  endfunction

  logic             accept;
  logic             wr_dp;     // a write is in its data phase
  logic             ready_q;   // low during the read-after-write dead cycle
  logic [IDX_W-1:0] idx_q;
  logic [LANES-1:0] lanes_q;
  logic [IDX_W-1:0] idx_now;

  assign accept  = hsel & trans_active & hready;
  assign idx_now = addr_lo[LOW_W-1:OFF_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_dp   <= 1'b0;
      ready_q <= 1'b1;
      idx_q   <= '0;
      lanes_q <= '0;
    end else begin
      wr_dp   <= accept & hwrite;
      ready_q <= ~(accept & ~hwrite & wr_dp);
      if (accept) begin
        idx_q   <= idx_now;
        lanes_q <= lanes_for(hsize, addr_lo[OFF_W-1:0]);
      end
    end
  end

  // Bank port priority: pending write, then a stalled read, then a new read.
  always_comb begin
    bank_ce  = '0;
    bank_we  = '0;
    bank_idx = idx_q;
    if (wr_dp) begin
      bank_ce = lanes_q;
      bank_we = lanes_q;
    end else if (!ready_q) begin
      bank_ce = '1;
    end else if (accept && !hwrite) begin
      bank_ce  = '1;
      bank_idx = idx_now;
    end
  end

  assign hreadyout = ready_q;

endmodule

// File: rtl/ahb_byte_sram.sv
module ahb_byte_sram
  import ahb_sram_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4096,
  localparam int LANES = DATA_W / 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int OFF_W = $clog2(LANES),
  localparam int LOW_W = IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [2:0]        hsize,
  input  logic [DATA_W-1:0] hwdata,
  input  logic              hready,
  output logic [DATA_W-1:0] hrdata,
  output logic              hreadyout,
  output logic [1:0]        hresp
);

  logic [LANES-1:0] bank_ce;
  logic [LANES-1:0] bank_we;
  logic [IDX_W-1:0] bank_idx;
  logic             unused_bits;

  // Bits above the memory image alias; the decoder owns the window.
  assign unused_bits = ^{haddr[ADDR_W-1:LOW_W], htrans[0]};

  ahb_sram_ctrl #(
    .LANES (LANES),
    .DEPTH (DEPTH)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .hsel         (hsel),
    .addr_lo      (haddr[LOW_W-1:0]),
    .trans_active (htrans[1]),
    .hwrite       (hwrite),
    .hsize        (hsize),
    .hready       (hready),
    .hreadyout    (hreadyout),
    .bank_ce      (bank_ce),
    .bank_we      (bank_we),
    .bank_idx     (bank_idx)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    ahb_sram_bank #(
      .DEPTH (DEPTH),
      .WIDTH (8)
    ) u_bank (
      .clk  (clk),
      .ce   (bank_ce[k]),
      .we   (bank_we[k]),
      .idx  (bank_idx),
      .din  (hwdata[8*k +: 8]),
      .dout (hrdata[8*k +: 8])
    );
  end

  assign hresp = RSP_OKAY;

endmodule

// File: rtl/ahb_byte_sram_chk.sv
module ahb_byte_sram_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             hsel,
  input logic [1:0]       htrans,
  input logic             hwrite,
  input logic [2:0]       hsize,
  input logic             hready,
  input logic             hreadyout,
  input logic [1:0]       hresp,
  input logic [LANES-1:0] bank_ce,
  input logic [LANES-1:0] bank_we
);

  logic acc;
  logic wr_seen;
  logic unused_chk;

  assign acc        = hsel & htrans[1] & hready;
  assign unused_chk = htrans[0];

  always_ff @(posedge clk) begin
    if (rst) wr_seen <= 1'b0;
    else     wr_seen <= acc & hwrite;
  end

  assert_ready_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (hreadyout && hresp == 2'b00));

  assert_idle_no_access_R2: assert property (@(posedge clk) disable iff (rst)
    (!acc && !wr_seen && hreadyout) |-> (bank_ce == '0));

  assert_write_in_data_phase_R4: assert property (@(posedge clk) disable iff (rst)
    (|bank_we) |-> wr_seen);

  assert_half_two_lanes_R5: assert property (@(posedge clk) disable iff (rst)
    (acc && hwrite && hsize == 3'b001) |=> ($countones(bank_we) == 2));

  assert_byte_one_lane_R6: assert property (@(posedge clk) disable iff (rst)
    (acc && hwrite && hsize == 3'b000) |=> ($countones(bank_we) == 1));

  assert_raw_dead_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    (acc && !hwrite && wr_seen) |=> !hreadyout);

  assert_single_wait_R8: assert property (@(posedge clk) disable iff (rst)
    !hreadyout |=> hreadyout);

  assert_no_wait_R9: assert property (@(posedge clk) disable iff (rst)
    (acc && (hwrite || !wr_seen)) |=> hreadyout);

endmodule

bind ahb_byte_sram ahb_byte_sram_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .hsel      (hsel),
  .htrans    (htrans),
  .hwrite    (hwrite),
  .hsize     (hsize),
  .hready    (hready),
  .hreadyout (hreadyout),
  .hresp     (hresp),
  .bank_ce   (bank_ce),
  .bank_we   (bank_we)
);

// File: tb/ahb_byte_sram_bench.sv
module ahb_byte_sram_bench;

  localparam int DEPTH = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hsel = 1'b0;
  logic [31:0] haddr = '0;
  logic [1:0]  htrans = 2'b00;
  logic        hwrite = 1'b0;
  logic [2:0]  hsize = 3'b010;
  logic [31:0] hwdata = '0;
  logic        hready;
  logic [31:0] hrdata;
  logic        hreadyout;
  logic [1:0]  hresp;

  assign hready = hreadyout;

  always #10 clk = ~clk;

  ahb_byte_sram u_ahb_byte_sram (
    .clk, .rst, .hsel, .haddr, .htrans, .hwrite, .hsize,
    .hwdata, .hready, .hrdata, .hreadyout, .hresp
  );

  typedef struct {
    logic [31:0] data;
    int          waits;
    string       tag;
  } exp_t;

  exp_t        rdq[$];
  logic [31:0] model [DEPTH];
  bit          prev_wr = 1'b0;
  int          errors = 0;
  int          checks = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one transfer, pipelined with the next call.
  task automatic xfer(input bit wr, input logic [1:0] tr, input logic [31:0] addr,
                      input logic [2:0] sz, input logic [31:0] wd, input string tag);
    int idx;
    exp_t e;
    idx = int'(addr[13:2]);
    hsel = 1'b1; htrans = tr; haddr = addr; hwrite = wr; hsize = sz;
    if (wr) begin
      for (int k = 0; k < 4; k++) begin
        bit en;
        if (sz == 3'b000)      en = (k == int'(addr[1:0]));
        else if (sz == 3'b001) en = ((k / 2) == int'(addr[1]));
        else                   en = 1'b1;
        if (en) model[idx][8*k +: 8] = wd[8*k +: 8];
      end
    end else begin
      e.data = model[idx]; e.waits = prev_wr ? 1 : 0; e.tag = tag;
      rdq.push_back(e);
    end
    forever begin
      @(negedge clk);
      if (hready) break;
    end
    @(posedge clk); #1;
    hsel = 1'b0; htrans = 2'b00;
    if (wr) hwdata = wd;
    prev_wr = wr;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
    prev_wr = 1'b0;
  endtask

  // A write-looking cycle that must not be accepted.
  task automatic nonxfer(input bit sel, input logic [1:0] tr, input logic [31:0] addr,
                         input logic [31:0] wd);
    hsel = sel; htrans = tr; haddr = addr; hwrite = 1'b1; hsize = 3'b010;
    @(posedge clk); #1;
    hsel = 1'b0; htrans = 2'b00; hwdata = wd;
    @(posedge clk); #1;
    prev_wr = 1'b0;
  endtask

  // Monitor: pops the scoreboard when a read data phase completes.
  bit dp_rd = 1'b0;
  bit dp_wr = 1'b0;
  int waits = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (dp_wr) begin
        check(hreadyout, "R9 write data phase without wait", {31'd0, hreadyout}, 32'd1);
        dp_wr = 1'b0;
      end
      if (dp_rd) begin
        if (!hreadyout) begin
          waits++;
        end else begin
          exp_t e;
          if (rdq.size() == 0) begin
            check(1'b0, "scoreboard empty on read", hrdata, 32'd0);
          end else begin
            e = rdq.pop_front();
            check(hrdata == e.data, {e.tag, " data"}, hrdata, e.data);
            check(waits == e.waits, {e.tag, " wait cycles"}, waits, e.waits);
            check(hresp == 2'b00, "R10 response OKAY", {30'd0, hresp}, 32'd0);
          end
          dp_rd = 1'b0;
          waits = 0;
        end
      end
      if (hsel && htrans[1] && hready) begin
        if (hwrite) dp_wr = 1'b1;
        else        dp_rd = 1'b1;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(hreadyout == 1'b1, "R1 ready in reset", {31'd0, hreadyout}, 32'd1);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    check(hreadyout == 1'b1, "R1 ready after reset", {31'd0, hreadyout}, 32'd1);
    check(hresp == 2'b00, "R1 OKAY after reset", {30'd0, hresp}, 32'd0);
    @(posedge clk); #1;

    // R4 word writes back to back, then R8 read right after a write.
    for (int k = 0; k < 4; k++)
      xfer(1, 2'b10, 32'hC200_0000 + 32'(4*k), 3'b010, 32'h1111_0000 + 32'(k), "R4");
    xfer(0, 2'b10, 32'hC200_0008, 3'b010, 0, "R8 read after write");
    // R3/R9 reads back to back.
    xfer(0, 2'b10, 32'hC200_0000, 3'b010, 0, "R3 word read idx0");
    xfer(0, 2'b10, 32'hC200_0004, 3'b010, 0, "R9 read after read idx1");
    xfer(0, 2'b10, 32'hC200_000C, 3'b010, 0, "R9 read after read idx3");

    // R9 read separated from a write by one idle cycle, SEQ accepted (R2).
    xfer(1, 2'b11, 32'hC200_0010, 3'b010, 32'hA5A5_5A5A, "R2");
    idle(1);
    xfer(0, 2'b10, 32'hC200_0010, 3'b010, 0, "R9 read after gap / R2 SEQ write");

    // R8 same-word read right after write.
    xfer(1, 2'b10, 32'hC200_0020, 3'b010, 32'h0BAD_CAFE, "R8");
    xfer(0, 2'b10, 32'hC200_0020, 3'b010, 0, "R8 same word read after write");

    // R5 halfword lanes.
    xfer(1, 2'b10, 32'hC200_0040, 3'b010, 32'h0102_0304, "R5");
    xfer(1, 2'b10, 32'hC200_0040, 3'b001, 32'h7777_BEEF, "R5");
    idle(2);
    xfer(0, 2'b10, 32'hC200_0040, 3'b010, 0, "R5 low half");
    xfer(1, 2'b10, 32'hC200_0042, 3'b001, 32'hCAFE_8888, "R5");
    idle(1);
    xfer(0, 2'b10, 32'hC200_0040, 3'b010, 0, "R5 high half");

    // R6 byte lanes, read with byte size returns the whole word (R3).
    xfer(1, 2'b10, 32'hC200_0050, 3'b010, 32'h0000_0000, "R6");
    for (int k = 0; k < 4; k++)
      xfer(1, 2'b10, 32'hC200_0050 + 32'(k), 3'b000, {4{8'(8'h11 * (k + 1))}}, "R6");
    xfer(0, 2'b10, 32'hC200_0052, 3'b000, 0, "R6 byte lanes / R3 byte-size read");
    xfer(1, 2'b10, 32'hC200_0051, 3'b000, 32'hEEEE_EEEE, "R6");
    idle(1);
    xfer(0, 2'b10, 32'hC200_0050, 3'b010, 0, "R6 single byte update");

    // R7 aliasing above bit 13.
    xfer(1, 2'b10, 32'hC20F_F044, 3'b010, 32'h600D_F00D, "R7");
    idle(1);
    xfer(0, 2'b10, 32'hC200_3044, 3'b010, 0, "R7 alias read");
    xfer(0, 2'b10, 32'hC205_7044, 3'b010, 0, "R7 second alias read");

    // R2 IDLE, BUSY and deselected writes leave word 0 unchanged.
    nonxfer(1'b1, 2'b00, 32'hC200_0000, 32'hDEAD_BEEF);
    nonxfer(1'b1, 2'b01, 32'hC200_0000, 32'hDEAD_BEEF);
    nonxfer(1'b0, 2'b10, 32'hC200_0000, 32'hDEAD_BEEF);
    xfer(0, 2'b10, 32'hC200_0000, 3'b010, 0, "R2 ignored transfers");

    idle(4);
    check(rdq.size() == 0, "scoreboard drained", rdq.size(), 0);
    check(hresp == 2'b00, "R10 OKAY when idle", {30'd0, hresp}, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule